// File: doc/BRIEF.md
# SPI Register-Access Slave Front End

This block is an SPI slave that gives an external host access to a small register file living in the system clock domain. The host frames a chip-select low period and clocks any number of two-byte pairs through it: a command byte, then a data byte. The command byte chooses read or write and the register index. Each completed pair is handed across to the system clock by a toggle handshake. It is captured into system-clock registers and then committed to the register file.

The register file holds a 32-bit target address, the beat count of a burst (stored as count minus one), a 16-byte staging buffer, a control port and an engine status code. Bytes written to the staging port fill the buffer. When the last byte of a beat lands, the assembled beat is presented to the bus-side transfer engine with a one-cycle valid pulse. Control writes produce start and clear pulses for that engine, and the engine reports completion with its done input.

Reads are pipelined. A read command fetches a register value into a hold register, and that value is shifted out on MISO during the data byte of a later pair. Software therefore issues one extra read to collect the last result.

State machines:
- Pair commit FSM (system clock): `PS_WAIT` goes to `PS_CAPTURE` when the synchronised toggle differs from the last one seen. `PS_CAPTURE` latches the pair and always goes to `PS_COMMIT`. `PS_COMMIT` strobes the commit for one cycle and always returns to `PS_WAIT`.
- Engine FSM (system clock): `ENG_IDLE` goes to `ENG_BUSY` on a control write of 0x02. `ENG_BUSY` goes to `ENG_DONE` when `eng_done` is high. A control write of 0x00 returns any state to `ENG_IDLE`.

Top module: `spi_reg_bridge`

## Requirements
- R1: After reset, `tgt_addr`, `beat_last`, `beat_valid`, `xfer_start`, `xfer_clear` and `spi_miso` are all 0. The engine status is idle (0x00), and the read hold register is 0x00.
- R2: Writes to indices 0x00, 0x01, 0x02 and 0x03 set byte 0 (bits 7:0), byte 1, byte 2 and byte 3 of `tgt_addr` respectively.
- R3: A write to index 0x04 sets `beat_last`, which is the beat count minus one. A read of index 0x04 returns it.
- R4: Each write to index 0x07 stores one byte into the staging buffer, filling it from the least significant byte upward. On the 16th byte, `beat_valid` is high for exactly one cycle and `beat_data` holds the 16 bytes, the first written byte in bits 7:0. The buffer then starts over at byte 0.
- R5: Writing 0x02 to index 0x05 while the status is idle produces a one-cycle `xfer_start` pulse and sets the status to busy (0x01). While busy, `eng_done` high sets the status to done (0x02). Status is read at index 0x08.
- R6: Writing 0x00 to index 0x05 produces a one-cycle `xfer_clear` pulse from any state and sets the status to idle. It also returns the staging byte position to byte 0.
- R7: A read command (command bit 7 = 0) loads the value of the register it names into the hold register. MISO shifts the hold register during the data byte of each pair, MSB first, and reads 0 during the command byte. A read therefore returns the value fetched by the previous read command, and writes do not change the hold register.
- R8: Any number of pairs may be clocked within one chip-select low period. Raising chip select resets the bit position, so a partly clocked pair is discarded and has no effect.
- R9: A control write other than 0x00 or 0x02 has no effect. A write of 0x02 while the status is busy or done has no effect. Writes to indices 0x06 and to 0x09 and above have no effect. Reads of indices 0x05, 0x06, 0x07 and 0x09 and above return 0x00.
- R10: MOSI is sampled on the rising SPI clock edge and MISO changes on the falling edge. Both shift most significant bit first, and the command byte precedes the data byte. The low 7 bits of the command are the register index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| tgt_addr | output | 32 | Target address for the bus engine |
| beat_last | output | 8 | Number of beats minus one |
| beat_data | output | BEAT_BYTES*8 | Assembled staging beat |
| beat_valid | output | 1 | One-cycle pulse when a beat is complete |
| xfer_start | output | 1 | One-cycle pulse that starts the bus write |
| xfer_clear | output | 1 | One-cycle pulse that returns the engine to idle |
| eng_done | input | 1 | Engine reports that the write has completed |

## Verification
The hardest situation to reach from the ports is a pair that is abandoned partway through by chip select going high. The bench produces it by clocking a write command and only four bits of its data byte, then raising chip select. It checks that the addressed address byte is unchanged and that a following full pair is framed correctly. The one-transaction lag of read data is covered by a bench model of the hold register. Randomly chosen reads and writes across random chip-select framings are checked against that model, so a read must always return the value fetched by the previous read command, including across write pairs and chip-select boundaries.

// File: rtl/spi_reg_bridge_pkg.sv
package spi_reg_bridge_pkg;

    localparam int ADDR_BYTES = 4;

    localparam logic [6:0] IDX_BEATS  = 7'h04;
    localparam logic [6:0] IDX_CTRL   = 7'h05;
    localparam logic [6:0] IDX_STAGE  = 7'h07;
    localparam logic [6:0] IDX_STATUS = 7'h08;

    localparam logic [7:0] CTRL_CLEAR = 8'h00;
    localparam logic [7:0] CTRL_GO    = 8'h02;

    // Engine states double as the status code read at IDX_STATUS
    typedef enum logic [7:0] {
        ENG_IDLE = 8'h00,
        ENG_BUSY = 8'h01,
        ENG_DONE = 8'h02
    } eng_state_e;

    typedef enum logic [1:0] {
        PS_WAIT,
        PS_CAPTURE,
        PS_COMMIT
    } pair_state_e;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] dat;
    } spi_pair_t;

endpackage

// File: rtl/srb_spi_shifter.sv
module srb_spi_shifter
    import spi_reg_bridge_pkg::*;
(
    input  logic      rst_n,
    input  logic      spi_sck,
    input  logic      spi_cs_n,
    input  logic      spi_mosi,
    output logic      spi_miso,
    input  logic [7:0] rd_hold,
    output spi_pair_t pair_out,
    output logic      pair_tgl
);

    logic [3:0] bit_cnt;
    logic [6:0] shreg;
    logic [7:0] cmd_q;
    logic [7:0] rx_byte;
    logic [6:0] tx_sh;

    assign rx_byte = {shreg, spi_mosi};

    // Receive side: rising edge, framed by chip select
    always_ff @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            bit_cnt <= 4'd0;
            shreg   <= 7'd0;
            cmd_q   <= 8'd0;
        end else begin
            bit_cnt <= bit_cnt + 4'd1;
            shreg   <= rx_byte[6:0];
            if (bit_cnt == 4'd7) begin
                cmd_q <= rx_byte;
            end
        end
    end

    // Completed pair: held stable until the next pair completes
    always_ff @(posedge spi_sck or negedge rst_n) begin
        if (!rst_n) begin
            pair_out <= '0;
            pair_tgl <= 1'b0;
        end else if (bit_cnt == 4'd15) begin
            pair_out.cmd <= cmd_q;
            pair_out.dat <= rx_byte;
            pair_tgl     <= ~pair_tgl;
        end
    end

    // Transmit side: falling edge, hold register during the data byte
    always_ff @(negedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            spi_miso <= 1'b0;
            tx_sh    <= 7'd0;
        end else if (bit_cnt == 4'd8) begin
            spi_miso <= rd_hold[7];
            tx_sh    <= rd_hold[6:0];
        end else if (bit_cnt > 4'd8) begin
            spi_miso <= tx_sh[6];
            tx_sh    <= {tx_sh[5:0], 1'b0};
        end else begin
            spi_miso <= 1'b0;
            tx_sh    <= 7'd0;
        end
    end

endmodule

// File: rtl/srb_pair_sync.sv
module srb_pair_sync
    import spi_reg_bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pair_tgl,
    input  spi_pair_t pair_in,
    output logic      commit,
    output spi_pair_t commit_pair
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   tgl_s;
    logic                   seen_q;
    pair_state_e            ps_q, ps_d;

    assign tgl_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pair_tgl};
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= PS_WAIT;
        end else begin
            ps_q <= ps_d;
        end
    end

    // Next state
    always_comb begin
        ps_d = ps_q;
        unique case (ps_q)
            PS_WAIT:    if (tgl_s != seen_q) ps_d = PS_CAPTURE;
            PS_CAPTURE: ps_d = PS_COMMIT;
            PS_COMMIT:  ps_d = PS_WAIT;
            default:    ps_d = PS_WAIT;
        endcase
    end

    // Outputs: capture the pair, then commit it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_pair <= '0;
            seen_q      <= 1'b0;
        end else if (ps_q == PS_CAPTURE) begin
            commit_pair <= pair_in;
            seen_q      <= tgl_s;
        end
    end

    assign commit = (ps_q == PS_COMMIT);

    // The crossing pair must be settled when it is captured
    assert_pair_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_q == PS_CAPTURE) |-> $stable(pair_in));

    // A commit strobe is never repeated for the same pair
    assert_commit_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/srb_reg_file.sv
module srb_reg_file
    import spi_reg_bridge_pkg::*;
#(
    parameter int BEAT_BYTES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  spi_pair_t                 cpair,
    input  logic                      eng_done,
    output logic [ADDR_BYTES*8-1:0]   tgt_addr,
    output logic [7:0]                beat_last,
    output logic [BEAT_BYTES*8-1:0]   beat_data,
    output logic                      beat_valid,
    output logic                      xfer_start,
    output logic                      xfer_clear,
    output logic [7:0]                rd_hold
);

    localparam int PTR_W = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(BEAT_BYTES - 1);

    logic       is_wr, is_rd;
    logic [6:0] idx;
    logic       wr_stage, cmd_go, cmd_clear;
    logic [7:0] rd_next;

    logic [7:0]       addr_b  [ADDR_BYTES];
    logic [7:0]       stage_b [BEAT_BYTES];
    logic [PTR_W-1:0] ptr_q;

    eng_state_e eng_q, eng_d;

    assign is_wr     = commit & cpair.cmd[7];
    assign is_rd     = commit & ~cpair.cmd[7];
    assign idx       = cpair.cmd[6:0];
    assign wr_stage  = is_wr && (idx == IDX_STAGE);
    assign cmd_go    = is_wr && (idx == IDX_CTRL) && (cpair.dat == CTRL_GO);
    assign cmd_clear = is_wr && (idx == IDX_CTRL) && (cpair.dat == CTRL_CLEAR);

    // Address bytes and beat count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < ADDR_BYTES; b++) addr_b[b] <= 8'd0;
            beat_last <= 8'd0;
        end else if (is_wr) begin
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (idx == 7'(b)) addr_b[b] <= cpair.dat;
            end
            if (idx == IDX_BEATS) beat_last <= cpair.dat;
        end
    end

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr_out
        assign tgt_addr[g*8 +: 8] = addr_b[g];
    end

    // Staging buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BEAT_BYTES; b++) stage_b[b] <= 8'd0;
            ptr_q      <= '0;
            beat_valid <= 1'b0;
        end else begin
            beat_valid <= 1'b0;
            if (cmd_clear) begin
                ptr_q <= '0;
            end else if (wr_stage) begin
                stage_b[ptr_q] <= cpair.dat;
                if (ptr_q == PTR_LAST) begin
                    ptr_q      <= '0;
                    beat_valid <= 1'b1;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < BEAT_BYTES; g++) begin : g_beat_out
        assign beat_data[g*8 +: 8] = stage_b[g];
    end

    // Engine FSM: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= ENG_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    // Engine FSM: next state
    always_comb begin
        eng_d = eng_q;
        if (cmd_clear) begin
            eng_d = ENG_IDLE;
        end else begin
            unique case (eng_q)
                ENG_IDLE: if (cmd_go)   eng_d = ENG_BUSY;
                ENG_BUSY: if (eng_done) eng_d = ENG_DONE;
                ENG_DONE: eng_d = ENG_DONE;
                default:  eng_d = ENG_IDLE;
            endcase
        end
    end

    // Engine FSM: output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_start <= 1'b0;
            xfer_clear <= 1'b0;
        end else begin
            xfer_start <= cmd_go && (eng_q == ENG_IDLE);
            xfer_clear <= cmd_clear;
        end
    end

    // Read path into the hold register
    always_comb begin
        rd_next = 8'h00;
        for (int b = 0; b < ADDR_BYTES; b++) begin
            if (idx == 7'(b)) rd_next = addr_b[b];
        end
        if (idx == IDX_BEATS)  rd_next = beat_last;
        if (idx == IDX_STATUS) rd_next = eng_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_hold <= 8'h00;
        end else if (is_rd) begin
            rd_hold <= rd_next;
        end
    end

    assert_beat_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |=> !beat_valid);

    assert_beat_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (ptr_q == '0));

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    assert_done_from_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q == ENG_DONE) |-> ($past(eng_q) == ENG_BUSY && $past(eng_done)));

    assert_clear_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_clear |-> (eng_q == ENG_IDLE));

    assert_hold_on_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(is_rd) |-> $stable(rd_hold));

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
    import spi_reg_bridge_pkg::*;
#(
    parameter int BEAT_BYTES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sck,
    input  logic                    spi_cs_n,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    output logic [31:0]             tgt_addr,
    output logic [7:0]              beat_last,
    output logic [BEAT_BYTES*8-1:0] beat_data,
    output logic                    beat_valid,
    output logic                    xfer_start,
    output logic                    xfer_clear,
    input  logic                    eng_done
);

    spi_pair_t  spi_pair;
    spi_pair_t  commit_pair;
    logic       pair_tgl;
    logic       commit;
    logic [7:0] rd_hold;

    srb_spi_shifter u_shifter (
        .rst_n    (rst_n),
        .spi_sck  (spi_sck),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .rd_hold  (rd_hold),
        .pair_out (spi_pair),
        .pair_tgl (pair_tgl)
    );

    srb_pair_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair_tgl    (pair_tgl),
        .pair_in     (spi_pair),
        .commit      (commit),
        .commit_pair (commit_pair)
    );

    srb_reg_file #(
        .BEAT_BYTES (BEAT_BYTES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .cpair      (commit_pair),
        .eng_done   (eng_done),
        .tgt_addr   (tgt_addr),
        .beat_last  (beat_last),
        .beat_data  (beat_data),
        .beat_valid (beat_valid),
        .xfer_start (xfer_start),
        .xfer_clear (xfer_clear),
        .rd_hold    (rd_hold)
    );

endmodule

// File: tb/spi_reg_bridge_bench.sv
module spi_reg_bridge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SCK_HALF   = 40;
    localparam int NBYTES     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic eng_done = 1'b0;
    logic spi_miso;
    logic [31:0] tgt_addr;
    logic [7:0] beat_last;
    logic [NBYTES*8-1:0] beat_data;
    logic beat_valid, xfer_start, xfer_clear;

    spi_reg_bridge u_spi_reg_bridge (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .tgt_addr(tgt_addr),
        .beat_last(beat_last), .beat_data(beat_data), .beat_valid(beat_valid),
        .xfer_start(xfer_start), .xfer_clear(xfer_clear), .eng_done(eng_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int starts = 0;
    int clears = 0;
    int beats = 0;
    logic [NBYTES*8-1:0] beat_log [8];

    // Model state
    logic [31:0] m_addr = 32'd0;
    logic [7:0]  m_beats = 8'd0;
    logic [7:0]  m_status = 8'd0;
    logic [7:0]  m_hold = 8'd0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_start) starts++;
            if (xfer_clear) clears++;
            if (beat_valid) begin
                if (beats < 8) beat_log[beats] = beat_data;
                beats++;
            end
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_reg(input logic [6:0] idx);
        if (idx <= 7'd3) return m_addr[8*idx[1:0] +: 8];
        if (idx == 7'd4) return m_beats;
        if (idx == 7'd8) return m_status;
        return 8'h00;
    endfunction

    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'd0;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = tx[7-i];
            #SCK_HALF;
            rx = {rx[6:0], spi_miso};
            spi_sck = 1'b1;
            #SCK_HALF;
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_on();
        spi_cs_n = 1'b0;
        #SCK_HALF;
    endtask

    task automatic cs_off();
        #SCK_HALF;
        spi_cs_n = 1'b1;
        #(SCK_HALF*2);
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic spi_pair(input logic [7:0] cmd, input logic [7:0] dat, output logic [7:0] rx);
        logic [7:0] junk;
        spi_bits(cmd, 8, junk);
        spi_bits(dat, 8, rx);
        #(SCK_HALF*2);
    endtask

    task automatic do_write(input logic [6:0] idx, input logic [7:0] dat);
        logic [7:0] rx;
        spi_pair({1'b1, idx}, dat, rx);
        check("R7 miso during write pair", rx, m_hold);
        if (idx <= 7'd3) m_addr[8*idx[1:0] +: 8] = dat;
        if (idx == 7'd4) m_beats = dat;
        if (idx == 7'd5) begin
            if (dat == 8'h00) m_status = 8'h00;
            else if (dat == 8'h02 && m_status == 8'h00) m_status = 8'h01;
        end
    endtask

    task automatic do_read(input logic [6:0] idx, input string req);
        logic [7:0] rx;
        spi_pair({1'b0, idx}, 8'h00, rx);
        check(req, rx, m_hold);
        m_hold = model_reg(idx);
    endtask

    logic [NBYTES*8-1:0] exp_beat [3];

    initial begin
        #(CLK_PERIOD*150000);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] junk;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 tgt_addr", tgt_addr, 32'd0);
        check("R1 beat_last", beat_last, 8'd0);
        check("R1 pulses", {beat_valid, xfer_start, xfer_clear}, 3'b000);
        check("R1 miso", spi_miso, 1'b0);

        // Directed burst under one chip select: R2 R3 R4 R5 R8
        for (int b = 0; b < 2; b++) begin
            for (int w = 0; w < 4; w++) exp_beat[b][w*32 +: 32] = $urandom;
        end
        cs_on();
        do_write(7'd0, 8'h00);
        do_write(7'd1, 8'h10);
        do_write(7'd2, 8'h00);
        do_write(7'd3, 8'h40);
        do_write(7'd4, 8'd1);
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < NBYTES; i++) do_write(7'd7, exp_beat[b][i*8 +: 8]);
        end
        do_write(7'd5, 8'h02);
        cs_off();
        settle();
        check("R2 address bytes", tgt_addr, 32'h4000_1000);
        check("R3 beat count", beat_last, 8'd1);
        check("R4 beat count pulses", beats, 2);
        check("R4 beat 0 data", beat_log[0], exp_beat[0]);
        check("R4 beat 1 data", beat_log[1], exp_beat[1]);
        check("R5 start pulse", starts, 1);
        check("R8 long burst clears none", clears, 0);

        // Pipelined reads: R7 R5
        cs_on();
        do_read(7'd8, "R7 first read returns reset hold");
        do_read(7'd8, "R5 status busy via lagged read");
        cs_off();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        m_status = 8'h02;
        cs_on();
        do_read(7'd4, "R7 lagged value after done");
        do_read(7'd8, "R3 beat count readback");
        do_write(7'd6, 8'h55);
        do_read(7'd2, "R5 status done, write did not disturb hold");
        cs_off();
        cs_on();
        do_read(7'd0, "R7 hold survives chip select");
        cs_off();

        // Ignored writes and reads: R9
        cs_on();
        do_write(7'd5, 8'h07);
        do_write(7'd5, 8'h02);
        do_write(7'd9, 8'h33);
        do_read(7'd6, "R9 read sequence");
        do_read(7'd9, "R9 index 6 reads zero");
        do_read(7'd5, "R9 index 9 reads zero");
        do_read(7'd8, "R9 control reads zero");
        do_read(7'd0, "R9 status still done");
        cs_off();
        settle();
        check("R9 no extra start", starts, 1);
        check("R9 no clear", clears, 0);
        check("R9 address unchanged", tgt_addr, m_addr);

        // Clear and staging restart: R6
        for (int w = 0; w < 4; w++) exp_beat[2][w*32 +: 32] = $urandom;
        cs_on();
        for (int i = 0; i < 5; i++) do_write(7'd7, 8'hA0 + 8'(i));
        do_write(7'd5, 8'h00);
        do_read(7'd8, "R6 read sequence");
        do_read(7'd8, "R6 status idle after clear");
        for (int i = 0; i < NBYTES; i++) do_write(7'd7, exp_beat[2][i*8 +: 8]);
        cs_off();
        settle();
        check("R6 clear pulse", clears, 1);
        check("R6 one beat after restart", beats, 3);
        check("R6 restarted beat data", beat_log[2], exp_beat[2]);
        check("R6 no start on clear", starts, 1);

        // Aborted pair: R8, then bit order R10
        cs_on();
        spi_bits(8'h81, 8, junk);
        spi_bits(8'hFF, 4, junk);
        cs_off();
        cs_on();
        do_write(7'd0, 8'h01);
        do_read(7'd0, "R8 read sequence");
        do_read(7'd1, "R10 msb-first readback of 0x01");
        cs_off();
        settle();
        check("R8 aborted pair discarded", tgt_addr, m_addr);

        // Random framing and accesses: R2 R3 R7 R8
        for (int it = 0; it < 40; it++) begin
            int nops;
            nops = 1 + int'($urandom_range(3));
            cs_on();
            for (int k = 0; k < nops; k++) begin
                if ($urandom_range(1) == 1) begin
                    do_write(7'($urandom_range(4)), 8'($urandom));
                end else begin
                    int ri;
                    ri = int'($urandom_range(5));
                    if (ri == 5) ri = 8;
                    do_read(7'(ri), "R7 random lagged read");
                end
            end
            cs_off();
        end
        settle();
        check("R2 random address", tgt_addr, m_addr);
        check("R3 random beat count", beat_last, m_beats);
        check("R5 no start from random", starts, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule